// File: doc/BRIEF.md
# Serial EEPROM Address-Phase Bus Master

This block opens an access to a serial EEPROM on a two-wire bus. When it receives a start pulse, it issues a start condition and then a control byte. After that it sends one or two address bytes. The slave must acknowledge each byte, and the block checks this. If every byte is acknowledged, the block pulses `done` and keeps the clock line held low, so that a data phase can follow. If any acknowledge is missing, the block stops sending bytes. It then forms a fresh start condition followed by a stop condition, sets a sticky timeout flag, and stays busy until the required bus-free interval has passed.

A static size input selects the addressing scheme. Small devices receive one address byte, and address bits 10 down to 8 travel in the select field of the control byte. Large devices receive a high address byte and then a low address byte, and the select field is sent as zeros. The block drives every requested address bit whatever device is attached.

Both bus wires are open-drain. An output-enable high pulls a wire low, and an enable low releases it. The block reads the data wire back through a synchronizer. A parameterised quarter-period timer sets the bit timing, and a separate counter sets the bus-free time.

Top module: `eeprom_addr_master`

## Requirements
- R1: The first byte after the start condition is the control byte, sent MSB first. Bits [7:4] are 1010, bits [3:1] are the select field and bit [0] is the write direction, which is 0.
- R2: With `size_strap`=0, two bytes are sent: the control byte with select = `cmd_addr[10:8]`, then `cmd_addr[7:0]`. Bits 15:11 are not transmitted.
- R3: With `size_strap`=1, three bytes are sent: the control byte with select = 000, then `cmd_addr[15:8]`, then `cmd_addr[7:0]`.
- R4: Each access begins with a start condition: SDA falls while SCL is released. Apart from start and stop conditions, SDA changes only while the master holds SCL low.
- R5: On the ninth clock of each byte the master releases SDA and samples it while SCL is high. Low means acknowledged and high means not acknowledged.
- R6: On a missing acknowledge, no further byte is sent. The master issues a start condition and then a stop condition, and `done` does not pulse.
- R7: `timeout` is set by an abort and stays set until `tout_clr` is asserted. A later successful access does not clear it.
- R8: On success, `done` is high for exactly one cycle and `busy` falls in the same cycle. No stop condition is sent, and SCL stays driven low afterwards.
- R9: A `cmd_start` that arrives while `busy` is high is ignored. The running access keeps its address and mode.
- R10: After the abort's stop condition, `busy` stays high for at least BUF_CYC cycles, with both wires released.
- R11: SDA is changed no sooner than QUARTER_CYC clock cycles after the master pulls SCL low.
- R12: After reset, `busy`, `done`, `timeout`, `scl_oe` and `sda_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle request to begin an access |
| cmd_addr | input | 16 | Target EEPROM address |
| size_strap | input | 1 | 0: one address byte, 1: two address bytes |
| tout_clr | input | 1 | Clears the sticky timeout flag |
| busy | output | 1 | Access or bus-free interval in progress |
| done | output | 1 | One-cycle pulse on a fully acknowledged address phase |
| timeout | output | 1 | Sticky missing-acknowledge flag |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA wire level |

## Verification
The bench builds the block with QUARTER_CYC=4 and BUF_CYC=24. A whole address phase then takes a few hundred cycles, so many accesses fit in one run. These values include acknowledge failures on the control byte, on the first address byte and on the last address byte, in both addressing modes. At this scale, the quarter-period hold margin and the bus-free interval after the abort's stop can be measured to the exact cycle. The bench's slave model runs on the wired-AND bus. It decodes start and stop conditions and captures every byte sent.

// File: rtl/eam_pkg.sv
package eam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_ASTART,
    ST_STOP,
    ST_FREE,
    ST_PARK
  } eam_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam logic       DIR_WR   = 1'b0;
  localparam int         BYTE_W   = 8;
  localparam int         MAX_BYTES = 3;
endpackage

// File: rtl/eam_quarter_timer.sv
module eam_quarter_timer #(
  parameter int QUARTER_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QUARTER_CYC > 1) ? $clog2(QUARTER_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) < QUARTER_CYC)); // R11
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (cnt_q == '0)); // R11
endmodule

// File: rtl/eam_bit_sync.sv
module eam_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[i] <= 1'b1;
          else        sh_q[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[i] <= 1'b1;
          else        sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/eam_frame_builder.sv
module eam_frame_builder
  import eam_pkg::*;
(
  input  logic [15:0]                  addr,
  input  logic                         wide,
  output logic [MAX_BYTES-1:0][BYTE_W-1:0] frame,
  output logic [1:0]                   last_idx
);
  logic [2:0] sel;

  always_comb begin
    sel      = wide ? 3'b000 : addr[10:8];
    frame[0] = {DEV_CODE, sel, DIR_WR};
    if (wide) begin
      frame[1] = addr[15:8];
      frame[2] = addr[7:0];
      last_idx = 2'd2;
    end else begin
      frame[1] = addr[7:0];
      frame[2] = 8'h00;
      last_idx = 2'd1;
    end
  end
endmodule

// File: rtl/eeprom_addr_master.sv
module eeprom_addr_master
  import eam_pkg::*;
#(
  parameter int QUARTER_CYC = 500,
  parameter int BUF_CYC     = 940,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic [15:0] cmd_addr,
  input  logic        size_strap,
  input  logic        tout_clr,
  output logic        busy,
  output logic        done,
  output logic        timeout,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int BUF_W = $clog2(BUF_CYC + 1);
  localparam logic [BUF_W-1:0] FREE_LAST = BUF_W'(BUF_CYC - 1);

  // reset: asserted asynchronously, released synchronously
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  eam_state_e state_q, state_d;
  logic [1:0]       phase_q, phase_d;
  logic [3:0]       bit_q, bit_d;
  logic [1:0]       byte_q, byte_d;
  logic             nack_q, nack_d;
  logic [15:0]      addr_q, addr_d;
  logic             wide_q, wide_d;
  logic [BUF_W-1:0] free_q, free_d;
  logic             done_q, done_d;
  logic             tout_q, tout_d;
  logic             scl_q, scl_d;
  logic             sda_q, sda_d;
  logic             tout_set;

  logic tick, run, sda_s;
  logic [MAX_BYTES-1:0][BYTE_W-1:0] frame;
  logic [1:0] last_idx;
  logic [2:0] bsel;
  logic       bit_val;

  assign run = (state_q == ST_START) || (state_q == ST_BITS) ||
               (state_q == ST_ASTART) || (state_q == ST_STOP);

  eam_quarter_timer #(.QUARTER_CYC(QUARTER_CYC)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .run(run), .tick(tick)
  );

  eam_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d(sda_in), .q(sda_s)
  );

  eam_frame_builder u_frame (
    .addr(addr_q), .wide(wide_q), .frame(frame), .last_idx(last_idx)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bit_d    = bit_q;
    byte_d   = byte_q;
    nack_d   = nack_q;
    addr_d   = addr_q;
    wide_d   = wide_q;
    free_d   = free_q;
    done_d   = 1'b0;
    tout_set = 1'b0;
    case (state_q)
      ST_IDLE, ST_PARK: begin
        if (cmd_start) begin
          state_d = ST_START;
          phase_d = 2'd0;
          addr_d  = cmd_addr;
          wide_d  = size_strap;
        end
      end
      ST_START: begin
        if (tick) begin
          phase_d = phase_q + 2'd1;
          if (phase_q == 2'd3) begin
            state_d = ST_BITS;
            bit_d   = 4'd0;
            byte_d  = 2'd0;
            nack_d  = 1'b0;
          end
        end
      end
      ST_BITS: begin
        if (tick) begin
          phase_d = phase_q + 2'd1;
          if (phase_q == 2'd2 && bit_q == 4'd8) nack_d = sda_s;
          if (phase_q == 2'd3) begin
            if (bit_q != 4'd8) begin
              bit_d = bit_q + 4'd1;
            end else if (nack_q) begin
              state_d = ST_ASTART;
            end else if (byte_q == last_idx) begin
              state_d = ST_PARK;
              done_d  = 1'b1;
            end else begin
              byte_d = byte_q + 2'd1;
              bit_d  = 4'd0;
            end
          end
        end
      end
      ST_ASTART: begin
        if (tick) begin
          phase_d = phase_q + 2'd1;
          if (phase_q == 2'd3) state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (tick) begin
          phase_d = phase_q + 2'd1;
          if (phase_q == 2'd3) begin
            state_d  = ST_FREE;
            free_d   = '0;
            tout_set = 1'b1;
          end
        end
      end
      ST_FREE: begin
        if (free_q == FREE_LAST) state_d = ST_IDLE;
        else                     free_d  = free_q + BUF_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase

    if (tout_set)      tout_d = 1'b1;
    else if (tout_clr) tout_d = 1'b0;
    else               tout_d = tout_q;
  end

  // line drive decoded from the next state, then registered
  always_comb begin
    bsel    = 3'(4'd7 - bit_d);
    bit_val = (bit_d < 4'd8) ? frame[byte_d][bsel] : 1'b1;
    scl_d   = 1'b0;
    sda_d   = 1'b0;
    case (state_d)
      ST_START, ST_ASTART: begin
        scl_d = 1'b0;
        sda_d = phase_d[1];
      end
      ST_BITS: begin
        scl_d = !phase_d[1];
        if (phase_d == 2'd0)    sda_d = sda_q;
        else if (bit_d == 4'd8) sda_d = 1'b0;
        else                    sda_d = !bit_val;
      end
      ST_STOP: begin
        scl_d = !phase_d[1];
        sda_d = (phase_d != 2'd3);
      end
      ST_PARK: begin
        scl_d = 1'b1;
        sda_d = 1'b0;
      end
      default: begin
        scl_d = 1'b0;
        sda_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      phase_q <= 2'd0;
      bit_q   <= 4'd0;
      byte_q  <= 2'd0;
      nack_q  <= 1'b0;
      addr_q  <= 16'h0000;
      wide_q  <= 1'b0;
      free_q  <= '0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      nack_q  <= nack_d;
      addr_q  <= addr_d;
      wide_q  <= wide_d;
      free_q  <= free_d;
      done_q  <= done_d;
      tout_q  <= tout_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
    end
  end

  assign busy    = (state_q != ST_IDLE) && (state_q != ST_PARK);
  assign done    = done_q;
  assign timeout = tout_q;
  assign scl_oe  = scl_q;
  assign sda_oe  = sda_q;

  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!scl_q && $past(!scl_q) && !$stable(sda_q)) |->
      (state_q == ST_START || state_q == ST_ASTART || state_q == ST_STOP)); // R4
  AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_BITS && bit_q == 4'd8 && phase_q != 2'd0) |-> !sda_q); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_q |=> !done_q); // R8
  AST_DONE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_q |-> (scl_q && !busy)); // R8
  AST_TOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tout_q && !tout_clr) |=> tout_q); // R7
  AST_BUSY_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && cmd_start) |=> ($stable(addr_q) && $stable(wide_q))); // R9
  AST_FREE_RELEASED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_FREE) |-> (!scl_q && !sda_q && busy)); // R10
endmodule

// File: tb/eeprom_addr_master_tb.sv
module eeprom_addr_master_tb;
  localparam int QC  = 4;
  localparam int BUF = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [15:0] cmd_addr = 16'h0000;
  logic        size_strap = 1'b0;
  logic        tout_clr = 1'b0;
  logic        busy, done, timeout, scl_oe, sda_oe, sda_in;
  logic        slv_pull = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign sda_in = ~(sda_oe | slv_pull);

  eeprom_addr_master #(.QUARTER_CYC(QC), .BUF_CYC(BUF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .size_strap(size_strap), .tout_clr(tout_clr), .busy(busy), .done(done),
    .timeout(timeout), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  // bus monitor and slave model
  int       cyc = 0;
  bit       prev_scl = 1'b1, prev_sda = 1'b1, prev_scl_oe = 1'b0, prev_sda_oe = 1'b0;
  bit       prev_busy = 1'b0;
  bit       in_frame = 1'b0;
  int       bitcnt = 0;
  int       rx_cnt = 0;
  logic [7:0] shreg = 8'h00;
  logic [7:0] rx [4];
  int       n_start = 0, n_stop = 0, nack_at = -1, hold_bad = 0;
  int       since_fall = 0, stop_cyc = 0, busy_fall_cyc = 0;
  bit       done_seen = 1'b0;

  always @(negedge clk) begin
    bit scl_l, sda_l;
    cyc++;
    scl_l = ~scl_oe;
    sda_l = sda_in;
    if (prev_scl && scl_l && prev_sda && !sda_l) begin
      n_start++; in_frame = 1'b1; bitcnt = 0;
    end else if (prev_scl && scl_l && !prev_sda && sda_l) begin
      n_stop++; stop_cyc = cyc;
    end
    if (in_frame && !prev_scl && scl_l) begin
      if (bitcnt < 8) begin
        shreg = {shreg[6:0], sda_l}; bitcnt++;
      end else begin
        if (rx_cnt < 4) rx[rx_cnt] = shreg;
        rx_cnt++; bitcnt = 0;
      end
    end
    if (in_frame && prev_scl && !scl_l)
      slv_pull = (bitcnt == 8) && (rx_cnt != nack_at);
    if (scl_oe && !prev_scl_oe) since_fall = 0;
    else since_fall++;
    if (scl_oe && prev_scl_oe && (sda_oe != prev_sda_oe) && since_fall < QC) hold_bad++;
    if (done) done_seen = 1'b1;
    if (prev_busy && !busy) busy_fall_cyc = cyc;
    prev_scl = scl_l; prev_sda = sda_in;
    prev_scl_oe = scl_oe; prev_sda_oe = sda_oe; prev_busy = busy;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctrl(input logic [15:0] a, input bit wide);
    return {4'b1010, (wide ? 3'b000 : a[10:8]), 1'b0};
  endfunction

  task automatic run_cmd(input logic [15:0] a, input bit wide, input int nack,
                         input bit poke);
    int guard = 0;
    @(negedge clk); #1;
    rx_cnt = 0; n_start = 0; n_stop = 0; in_frame = 1'b0; done_seen = 1'b0;
    nack_at = nack; hold_bad = 0; bitcnt = 0;
    cmd_addr = a; size_strap = wide; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      cmd_addr = ~a; size_strap = ~wide; cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
    end
    while (busy && guard < 20000) begin
      @(negedge clk); guard++;
    end
    chk(guard < 20000, "R8", "watchdog on busy", guard, 0);
    @(negedge clk); #1;
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R12", "busy after reset", busy, 0);
    chk(done == 1'b0, "R12", "done after reset", done, 0);
    chk(timeout == 1'b0, "R12", "timeout after reset", timeout, 0);
    chk(scl_oe == 1'b0, "R12", "scl_oe after reset", scl_oe, 0);
    chk(sda_oe == 1'b0, "R12", "sda_oe after reset", sda_oe, 0);
  endtask

  task automatic t_short(input logic [15:0] a);
    bit t0 = timeout;
    run_cmd(a, 1'b0, -1, 1'b0);
    chk(rx_cnt == 2, "R2", "byte count one-byte mode", rx_cnt, 2);
    chk(rx[0] == exp_ctrl(a, 1'b0), "R1", "control byte", rx[0], exp_ctrl(a, 1'b0));
    chk(rx[1] == a[7:0], "R2", "low address byte", rx[1], a[7:0]);
    chk(n_start == 1, "R4", "start count", n_start, 1);
    chk(n_stop == 0, "R8", "no stop on success", n_stop, 0);
    chk(done_seen, "R8", "done pulse seen", done_seen, 1);
    chk(scl_oe == 1'b1, "R8", "scl held low after done", scl_oe, 1);
    chk(hold_bad == 0, "R11", "sda hold violations", hold_bad, 0);
    chk(timeout == t0, "R5", "ack low keeps timeout", timeout, t0);
  endtask

  task automatic t_long(input logic [15:0] a);
    run_cmd(a, 1'b1, -1, 1'b0);
    chk(rx_cnt == 3, "R3", "byte count two-byte mode", rx_cnt, 3);
    chk(rx[0] == 8'hA0, "R3", "control byte select zero", rx[0], 8'hA0);
    chk(rx[1] == a[15:8], "R3", "high address byte", rx[1], a[15:8]);
    chk(rx[2] == a[7:0], "R3", "low address byte", rx[2], a[7:0]);
    chk(done_seen, "R8", "done pulse seen", done_seen, 1);
    chk(n_stop == 0, "R8", "no stop on success", n_stop, 0);
    chk(hold_bad == 0, "R11", "sda hold violations", hold_bad, 0);
  endtask

  task automatic t_nack(input logic [15:0] a, input bit wide, input int idx);
    run_cmd(a, wide, idx, 1'b0);
    chk(rx_cnt == idx + 1, "R6", "bytes sent before abort", rx_cnt, idx + 1);
    chk(rx[0] == exp_ctrl(a, wide), "R5", "control byte in nack run", rx[0], exp_ctrl(a, wide));
    chk(n_start == 2, "R6", "start count with abort", n_start, 2);
    chk(n_stop == 1, "R6", "stop count with abort", n_stop, 1);
    chk(!done_seen, "R6", "no done on abort", done_seen, 0);
    chk(timeout == 1'b1, "R7", "timeout set", timeout, 1);
    chk(busy_fall_cyc - stop_cyc >= BUF, "R10", "bus free cycles",
        busy_fall_cyc - stop_cyc, BUF);
    chk(!scl_oe && !sda_oe, "R10", "lines released after abort", {scl_oe, sda_oe}, 0);
    chk(hold_bad == 0, "R11", "sda hold violations", hold_bad, 0);
  endtask

  task automatic t_sticky;
    t_short(16'h0234);
    chk(timeout == 1'b1, "R7", "timeout survives success", timeout, 1);
    @(negedge clk); tout_clr = 1'b1;
    @(negedge clk); tout_clr = 1'b0;
    @(negedge clk);
    chk(timeout == 1'b0, "R7", "timeout cleared", timeout, 0);
  endtask

  task automatic t_busy_poke;
    run_cmd(16'h0123, 1'b0, -1, 1'b1);
    chk(rx_cnt == 2, "R9", "byte count unchanged by poke", rx_cnt, 2);
    chk(rx[0] == 8'hA2, "R9", "control byte unchanged by poke", rx[0], 8'hA2);
    chk(rx[1] == 8'h23, "R9", "address unchanged by poke", rx[1], 8'h23);
    chk(n_start == 1, "R9", "single start", n_start, 1);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_short(16'h05A3);
    t_short(16'hFFFF);
    t_long(16'hBEEF);
    t_long(16'h0001);
    t_nack(16'h0777, 1'b1, 0);
    t_sticky();
    t_nack(16'h1234, 1'b1, 2);
    t_nack(16'h0456, 1'b0, 1);
    @(negedge clk); tout_clr = 1'b1;
    @(negedge clk); tout_clr = 1'b0;
    t_busy_poke();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule